// File: doc/BRIEF.md
# Carry-Save Half-Adder Pipelined Adder

This block adds two unsigned operands of `WIDTH` bits and produces a `WIDTH+1`-bit sum. It has no carry-propagate adder. The sum is built from a chain of `WIDTH` carry-save rows made only of half adders. The first row combines the two operands directly. Each later row combines the running sum word with the running carry word moved up by one weight. After row `j`, sum bit `j` no longer changes. Result bits therefore settle one at a time, starting at the least significant bit.

The rows are grouped `GRAN` at a time into register stages, so there are `ceil(WIDTH/GRAN)` stages. The top result bit is a single OR column. It collects every carry that leaves the top weight of the carry word. Bits that settle early keep travelling in the stage registers, and those registers act as the deskew triangle. As a result the output word comes out aligned in bit-parallel form.

A new operand pair can be accepted on every clock. A valid flag travels with each pair and marks the aligned result on the output.

Top module: `csa_pipe_adder`

## Requirements
- R1: For every accepted pair, `out_sum` equals `in_a + in_b` as an unsigned `WIDTH+1`-bit value. Bit `WIDTH` is the carry out.
- R2: A pair accepted at a rising edge (`in_vld` high) appears with `out_vld` high exactly `ceil(WIDTH/GRAN)` rising edges later, counting the accepting edge. With `WIDTH`=8 and `GRAN`=3 this is 3 edges.
- R3: Pairs offered on consecutive cycles give one result per cycle, in the order they were accepted.
- R4: A cycle with `in_vld` low gives `out_vld` low exactly `ceil(WIDTH/GRAN)` cycles later. It does not disturb the results on either side of it.
- R5: `rst` is synchronous and active high. It clears every valid flag. `out_vld` is low on the cycle after any reset edge, and pairs that were in flight at reset never appear.
- R6: At most one carry ever enters the top result column for one operation. A plain OR therefore forms bit `WIDTH`, including for all-ones plus all-ones and for all-ones plus one.
- R7: After the last row of each stage, all carry bits below that row's index are zero. At the output the carry word holds nothing below its top bit, so carry chains that run the full width resolve correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_vld | input | 1 | Operand pair present this cycle |
| in_a | input | WIDTH | First unsigned operand |
| in_b | input | WIDTH | Second unsigned operand |
| out_vld | output | 1 | Aligned sum present this cycle |
| out_sum | output | WIDTH+1 | Unsigned sum, carry out in the top bit |

## Verification
The assertions rely on two assumptions.
- Data words in a stage register are meaningful only while that stage's valid flag is high. The carry and top-column checks therefore look only at stages that hold a real pair.
- `in_vld` is a plain level with no handshake. The in-flight count assumes nothing is ever refused.

The stimulus respects both assumptions. It changes inputs only at falling edges, keeps reset long enough to flush every stage, and feeds only full unsigned words. These include all-ones, zero, alternating patterns and carries that run the full width, interleaved with idle cycles.

// File: rtl/csa_pipe_pkg.sv
package csa_pipe_pkg;

   // number of register stages that hold w carry-save rows, g rows each
   function automatic int unsigned stage_count(input int unsigned w, input int unsigned g);
      return (w + g - 1) / g;
   endfunction

   // rows that land in stage k (the last stage may be short)
   function automatic int unsigned rows_in_stage(input int unsigned k, input int unsigned w,
                                                 input int unsigned g);
      return ((w - k * g) < g) ? (w - k * g) : g;
   endfunction

endpackage

// File: rtl/csa_ha_row.sv
module csa_ha_row #(
   parameter int unsigned W     = 8,
   parameter bit          FIRST = 1'b0
) (
   input  logic [W-1:0] sum_i,
   input  logic [W-1:0] cry_i,
   input  logic         top_i,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] cry_o,
   output logic         top_o
);

   logic [W-1:0] addend;

   generate
      if (FIRST) begin : g_first
         // operands enter aligned, nothing leaves the top yet
         assign addend = cry_i;
         assign top_o  = top_i;
      end else begin : g_step
         // carry word moves up one weight; its top bit drops into the OR column
         assign addend = {cry_i[W-2:0], 1'b0};
         assign top_o  = top_i | cry_i[W-1];
      end
   endgenerate

   for (genvar j = 0; j < W; j++) begin : g_ha
      assign sum_o[j] = sum_i[j] ^ addend[j];
      assign cry_o[j] = sum_i[j] & addend[j];
   end

endmodule

// File: rtl/csa_stage.sv
module csa_stage #(
   parameter int unsigned W     = 8,
   parameter int unsigned ROW0  = 0,
   parameter int unsigned NROWS = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         vld_i,
   input  logic [W-1:0] sum_i,
   input  logic [W-1:0] cry_i,
   input  logic         top_i,
   output logic         vld_o,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] cry_o,
   output logic         top_o
);

   localparam int unsigned LAST_ROW = ROW0 + NROWS - 1;

   if (NROWS < 1) begin : g_bad_rows
      $error("csa_stage: a stage needs at least one row");
   end

   logic [W-1:0] s_w [0:NROWS];
   logic [W-1:0] c_w [0:NROWS];
   logic         t_w [0:NROWS];

   assign s_w[0] = sum_i;
   assign c_w[0] = cry_i;
   assign t_w[0] = top_i;

   for (genvar r = 0; r < NROWS; r++) begin : g_row
      csa_ha_row #(
         .W     (W),
         .FIRST ((ROW0 + r) == 0)
      ) u_row (
         .sum_i (s_w[r]),
         .cry_i (c_w[r]),
         .top_i (t_w[r]),
         .sum_o (s_w[r+1]),
         .cry_o (c_w[r+1]),
         .top_o (t_w[r+1])
      );
   end

   // settled low sum bits ride along unchanged: these flops form the deskew triangle
   always_ff @(posedge clk) begin
      sum_o <= s_w[NROWS];
      cry_o <= c_w[NROWS];
      top_o <= t_w[NROWS];
   end

   always_ff @(posedge clk) begin
      if (rst) vld_o <= 1'b0;
      else     vld_o <= vld_i;
   end

   AST_TOP_SINGLE_CARRY: assert property (@(posedge clk) disable iff (rst)
      vld_o |-> !(top_o && cry_o[W-1])); // R6

   if (LAST_ROW > 0) begin : g_settle_chk
      localparam logic [W-1:0] SETTLED_MASK = (W'(1) << LAST_ROW) - W'(1);
      AST_CARRY_SETTLED: assert property (@(posedge clk) disable iff (rst)
         vld_o |-> ((cry_o & SETTLED_MASK) == '0)); // R7
   end

endmodule

// File: rtl/csa_pipe_adder.sv
module csa_pipe_adder #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned GRAN  = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_vld,
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   output logic             out_vld,
   output logic [WIDTH:0]   out_sum
);

   localparam int unsigned NST = csa_pipe_pkg::stage_count(WIDTH, GRAN);
   localparam int unsigned CW  = $clog2(NST + 1) + 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("csa_pipe_adder: WIDTH must be at least 2");
   end
   if (GRAN < 1 || GRAN > WIDTH) begin : g_bad_gran
      $error("csa_pipe_adder: GRAN must lie in 1..WIDTH");
   end

   logic             v_p [0:NST];
   logic [WIDTH-1:0] s_p [0:NST];
   logic [WIDTH-1:0] c_p [0:NST];
   logic             t_p [0:NST];

   assign v_p[0] = in_vld;
   assign s_p[0] = in_a;
   assign c_p[0] = in_b;
   assign t_p[0] = 1'b0;

   for (genvar k = 0; k < NST; k++) begin : g_stage
      localparam int unsigned ROWS_K = csa_pipe_pkg::rows_in_stage(k, WIDTH, GRAN);
      csa_stage #(
         .W     (WIDTH),
         .ROW0  (k * GRAN),
         .NROWS (ROWS_K)
      ) u_stage (
         .clk   (clk),
         .rst   (rst),
         .vld_i (v_p[k]),
         .sum_i (s_p[k]),
         .cry_i (c_p[k]),
         .top_i (t_p[k]),
         .vld_o (v_p[k+1]),
         .sum_o (s_p[k+1]),
         .cry_o (c_p[k+1]),
         .top_o (t_p[k+1])
      );
   end

   // last carry left at the top weight joins the OR column
   assign out_vld = v_p[NST];
   assign out_sum = {t_p[NST] | c_p[NST][WIDTH-1], s_p[NST]};

   // occupancy count for the latency and ordering checks
   logic [CW-1:0] inflight;
   always_ff @(posedge clk) begin
      if (rst) inflight <= '0;
      else     inflight <= inflight + CW'(in_vld) - CW'(out_vld);
   end

   AST_SUM_RESOLVED: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (c_p[NST][WIDTH-2:0] == '0)); // R7
   AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
      inflight <= CW'(NST)); // R2
   AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (inflight != '0)); // R4
   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_vld); // R5

endmodule

// File: tb/csa_pipe_adder_bench.sv
module csa_pipe_adder_bench;

   localparam int unsigned W   = 8;
   localparam int unsigned G   = 3;
   localparam int unsigned NST = (W + G - 1) / G;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_vld = 1'b0;
   logic [W-1:0] in_a = '0;
   logic [W-1:0] in_b = '0;
   logic         out_vld;
   logic [W:0]   out_sum;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic       h_v [NST];
   logic [W:0] h_s [NST];

   always #4 clk = ~clk;

   csa_pipe_adder #(.WIDTH(W), .GRAN(G)) u_csa_pipe_adder (
      .clk     (clk),
      .rst     (rst),
      .in_vld  (in_vld),
      .in_a    (in_a),
      .in_b    (in_b),
      .out_vld (out_vld),
      .out_sum (out_sum)
   );

   // one cycle: check what the last edge produced, then drive the next inputs
   task automatic step(input string tag, input logic v, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic r);
      @(negedge clk);
      checks++;
      if (out_vld !== h_v[NST-1] || (h_v[NST-1] && out_sum !== h_s[NST-1])) begin
         fails++;
         $display("FAIL %s: out_vld=%0b out_sum=%0h expected out_vld=%0b out_sum=%0h",
                  tag, out_vld, out_sum, h_v[NST-1], h_s[NST-1]);
      end
      for (int i = NST - 1; i > 0; i--) begin
         h_v[i] = h_v[i-1];
         h_s[i] = h_s[i-1];
      end
      h_v[0] = v & ~r;
      h_s[0] = {1'b0, a} + {1'b0, b};
      if (r) for (int i = 0; i < NST; i++) h_v[i] = 1'b0;
      rst = r; in_vld = v; in_a = a; in_b = b;
   endtask

   task automatic drain(input string tag);
      for (int i = 0; i < NST + 1; i++) step(tag, 1'b0, '0, '0, 1'b0);
   endtask

   task automatic t_reset;
      for (int i = 0; i < NST + 1; i++) step("R5", 1'b1, W'($urandom), W'($urandom), 1'b1);
      drain("R5");
   endtask

   task automatic t_latency;
      int seen;
      seen = -1;
      step("R2", 1'b1, 8'h3C, 8'h0F, 1'b0);
      for (int i = 1; i <= NST + 2; i++) begin
         step("R2", 1'b0, '0, '0, 1'b0);
         if (out_vld && seen < 0) seen = i;
      end
      checks++;
      if (seen != int'(NST)) begin
         fails++;
         $display("FAIL R2: latency=%0d expected=%0d", seen, NST);
      end
   endtask

   task automatic t_corner;
      step("R1", 1'b1, 8'h00, 8'h00, 1'b0);
      step("R6", 1'b1, 8'hFF, 8'hFF, 1'b0);
      step("R6", 1'b1, 8'hFF, 8'h01, 1'b0);
      step("R7", 1'b1, 8'h01, 8'hFF, 1'b0);
      step("R1", 1'b1, 8'hAA, 8'h55, 1'b0);
      step("R1", 1'b1, 8'h55, 8'h55, 1'b0);
      step("R6", 1'b1, 8'h80, 8'h80, 1'b0);
      step("R7", 1'b1, 8'h7F, 8'h01, 1'b0);
      step("R1", 1'b1, 8'hAA, 8'hAA, 1'b0);
      drain("R1");
   endtask

   task automatic t_random;
      for (int i = 0; i < 40; i++) step("R3", 1'b1, W'($urandom), W'($urandom), 1'b0);
      drain("R3");
   endtask

   task automatic t_gaps;
      step("R4", 1'b1, 8'h12, 8'h34, 1'b0);
      step("R4", 1'b0, 8'hFF, 8'hFF, 1'b0);
      step("R4", 1'b1, 8'hF0, 8'h0F, 1'b0);
      step("R4", 1'b1, 8'hC3, 8'h3D, 1'b0);
      step("R4", 1'b0, 8'h55, 8'hAA, 1'b0);
      step("R4", 1'b0, 8'h01, 8'h01, 1'b0);
      step("R4", 1'b1, 8'hFE, 8'h02, 1'b0);
      drain("R4");
   endtask

   task automatic t_reset_midflight;
      step("R5", 1'b1, 8'hFF, 8'hFF, 1'b0);
      step("R5", 1'b1, 8'h11, 8'h22, 1'b0);
      step("R5", 1'b0, 8'h00, 8'h00, 1'b1);
      drain("R5");
      step("R5", 1'b1, 8'h9C, 8'h77, 1'b0);
      drain("R5");
   endtask

   initial begin
      for (int i = 0; i < NST; i++) begin
         h_v[i] = 1'b0;
         h_s[i] = '0;
      end
      t_reset();
      t_latency();
      t_corner();
      t_random();
      t_gaps();
      t_reset_midflight();
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R3: cycles=5000 expected run to complete earlier");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule